// File: doc/BRIEF.md
# Cartridge Bank and Mirroring Controller

This block sits on the CPU bus of a game cartridge. Software programs it only by writes to exact 16-bit addresses, and it keeps a small set of bank numbers. Two of these are 8 KB program-ROM banks. Eight are 1 KB character-ROM banks. The last is a 2-bit nametable mirroring mode. From these registers the block turns a CPU address in the upper half of the map into a program-ROM address. It turns a video-side pattern address into a character-ROM address, and it picks one of two nametable pages for every video nametable access.

Each program bank is loaded with a single write. Each 8-bit character bank number is loaded one nibble at a time through an adjacent pair of addresses, so a full bank update takes two writes. The top two 8 KB program windows always map to the last two banks of the ROM. The ROM size is set by a parameter. The register writes take effect on a clock edge. The address translations are combinational from the current register contents.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, window 0x8000–0x9FFF maps bank 0 and window 0xA000–0xBFFF maps bank 1. Character bank register i holds i for i = 0..7, and the mirroring mode is 0 (vertical).
- R2: A write to 0x8000 loads the bank of window 0x8000–0x9FFF, and a write to 0xA000 loads the bank of window 0xA000–0xBFFF. Only data[PRG_BANK_W-1:0] is kept. prg_addr = {bank, cpu_addr[12:0]}, and the window is chosen by cpu_addr[14:13].
- R3: Window 0xC000–0xDFFF always maps bank PRG_BANKS-2, and window 0xE000–0xFFFF always maps bank PRG_BANKS-1. A write to those addresses never moves them.
- R4: A write to 0x9000 loads the mirroring mode from data[1:0]. data[7:2] is ignored.
- R5: nt_page equals vid_addr[10] in mode 0 and vid_addr[11] in mode 1. It is constant 0 in mode 2 and constant 1 in mode 3.
- R6: Character bank registers 0..7 are written through the address pairs 0xB000/0xB001, 0xB002/0xB003, 0xC000/0xC001, 0xC002/0xC003, 0xD000/0xD001, 0xD002/0xD003, 0xE000/0xE001 and 0xE002/0xE003, in that register order.
- R7: A write to the even address of a pair replaces bits [3:0] of the register with data[3:0]. A write to the odd address replaces bits [7:4] with data[3:0]. The other nibble is unchanged, and data[7:4] is ignored.
- R8: chr_addr = {register[vid_addr[12:10]], vid_addr[9:0]}.
- R9: A write to any address not listed in R2, R4 or R6 (for example 0x8001, 0x9001, 0xB004, 0xF00C) changes no register. Bus cycles with cpu_wr_en low change nothing either.
- R10: A write becomes visible on the outputs only after the rising clock edge at which cpu_wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_addr | input | 16 | CPU address, used for write decode and for program translation |
| cpu_wdata | input | 8 | CPU write data |
| prg_addr | output | PRG_BANK_W+13 | Program-ROM byte address |
| vid_addr | input | 14 | Video-side address |
| chr_addr | output | 18 | Character-ROM byte address |
| nt_page | output | 1 | Selected nametable page |

## Verification
The bench targets the nibble split of the character registers. A wrong design would clear or overwrite the partner nibble, or it would pass data[7:4] through, and the read-back through chr_addr exposes both faults. It also targets the pair-to-register ordering across the 0xB000–0xE003 span, where an off-by-one group decode would land a write in the neighbouring register. Near-miss addresses such as 0x8001, 0x9001 and 0xB004, and writes to the fixed windows, are issued to catch a decoder that matches too few address bits. The bench also checks the single-screen modes against both states of vid_addr[10] and vid_addr[11], and that a write is not visible before its clock edge.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    localparam logic [15:0] ADDR_PRG_A  = 16'h8000;
    localparam logic [15:0] ADDR_PRG_B  = 16'hA000;
    localparam logic [15:0] ADDR_MIRROR = 16'h9000;

    localparam int CHR_REGS   = 8;
    localparam int CHR_SEL_W  = $clog2(CHR_REGS);
    localparam int CHR_BANK_W = 8;
    localparam int CHR_PAGE_W = 10;
    localparam int PRG_PAGE_W = 13;

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
#(
    parameter int PRG_BANK_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [15:0]                           addr,
    input  logic [7:0]                            wdata,
    output logic [PRG_BANK_W-1:0]                 prg_a_q,
    output logic [PRG_BANK_W-1:0]                 prg_b_q,
    output mirror_e                               mirror_q,
    output logic [CHR_REGS-1:0][CHR_BANK_W-1:0]   chr_q
);

    typedef struct packed {
        logic [PRG_BANK_W-1:0]               prg_a;
        logic [PRG_BANK_W-1:0]               prg_b;
        mirror_e                             mirror;
        logic [CHR_REGS-1:0][CHR_BANK_W-1:0] chr;
    } state_t;

    state_t st_d, st_q;

    logic [3:0]           grp_off;
    logic                 hit_chr;
    logic                 hit_any;
    logic [CHR_SEL_W-1:0] chr_idx;

    function automatic state_t reset_state();
        state_t s;
        s.prg_a  = '0;
        s.prg_b  = PRG_BANK_W'(1);
        s.mirror = MIR_VERT;
        for (int i = 0; i < CHR_REGS; i++) begin
            s.chr[i] = CHR_BANK_W'(i);
        end
        return s;
    endfunction

    always_comb begin
        grp_off = addr[15:12] - 4'hB;
        hit_chr = (addr[15:12] >= 4'hB) && (addr[15:12] <= 4'hE)
                  && (addr[11:2] == 10'd0);
        chr_idx = {grp_off[1:0], addr[1]};
        hit_any = hit_chr || (addr == ADDR_PRG_A) || (addr == ADDR_PRG_B)
                  || (addr == ADDR_MIRROR);

        st_d = st_q;
        if (wr_en) begin
            if (addr == ADDR_PRG_A) begin
                st_d.prg_a = wdata[PRG_BANK_W-1:0];
            end else if (addr == ADDR_PRG_B) begin
                st_d.prg_b = wdata[PRG_BANK_W-1:0];
            end else if (addr == ADDR_MIRROR) begin
                st_d.mirror = mirror_e'(wdata[1:0]);
            end else if (hit_chr) begin
                if (addr[0]) begin
                    st_d.chr[chr_idx][7:4] = wdata[3:0];
                end else begin
                    st_d.chr[chr_idx][3:0] = wdata[3:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign prg_a_q  = st_q.prg_a;
    assign prg_b_q  = st_q.prg_b;
    assign mirror_q = st_q.mirror;
    assign chr_q    = st_q.chr;

    // Checker helpers: remember the target of the last nibble write.
    logic                  nib_chk_q;
    logic                  nib_hi_q;
    logic [CHR_SEL_W-1:0]  nib_idx_q;
    logic [CHR_BANK_W-1:0] nib_old_q;
    logic [3:0]            nib_dat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_chk_q <= 1'b0;
            nib_hi_q  <= 1'b0;
            nib_idx_q <= '0;
            nib_old_q <= '0;
            nib_dat_q <= '0;
        end else begin
            nib_chk_q <= wr_en && hit_chr;
            nib_hi_q  <= addr[0];
            nib_idx_q <= chr_idx;
            nib_old_q <= st_q.chr[chr_idx];
            nib_dat_q <= wdata[3:0];
        end
    end

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    assert_unlisted_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_any) |=> $stable(st_q));

    assert_mirror_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_MIRROR) |=> (st_q.mirror == $past(wdata[1:0])));

    assert_nibble_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nib_chk_q |-> (nib_hi_q ? (chr_q[nib_idx_q] == {nib_dat_q, nib_old_q[3:0]})
                                : (chr_q[nib_idx_q] == {nib_old_q[7:4], nib_dat_q})));

endmodule

// File: rtl/cbc_prg_map.sv
module cbc_prg_map
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS  = 32,
    parameter int PRG_BANK_W = 5
) (
    input  logic [15:0]                      cpu_addr,
    input  logic [PRG_BANK_W-1:0]            prg_a,
    input  logic [PRG_BANK_W-1:0]            prg_b,
    output logic [PRG_BANK_W+PRG_PAGE_W-1:0] prg_addr
);

    localparam logic [PRG_BANK_W-1:0] FIX_LO = PRG_BANK_W'(PRG_BANKS - 2);
    localparam logic [PRG_BANK_W-1:0] FIX_HI = PRG_BANK_W'(PRG_BANKS - 1);

    logic [PRG_BANK_W-1:0] bank;

    always_comb begin
        unique case (cpu_addr[14:13])
            2'b00:   bank = prg_a;
            2'b01:   bank = prg_b;
            2'b10:   bank = FIX_LO;
            default: bank = FIX_HI;
        endcase
        prg_addr = {bank, cpu_addr[PRG_PAGE_W-1:0]};
    end

    always_comb begin
        if (cpu_addr[14:13] == 2'b10) begin
            assert_fixed_low_R3: assert (prg_addr[PRG_BANK_W+PRG_PAGE_W-1:PRG_PAGE_W] == FIX_LO);
        end
        if (cpu_addr[14:13] == 2'b11) begin
            assert_fixed_high_R3: assert (prg_addr[PRG_BANK_W+PRG_PAGE_W-1:PRG_PAGE_W] == FIX_HI);
        end
    end

endmodule

// File: rtl/cbc_chr_map.sv
module cbc_chr_map
    import cbc_pkg::*;
(
    input  logic [13:0]                         vid_addr,
    input  logic [CHR_REGS-1:0][CHR_BANK_W-1:0] chr,
    input  mirror_e                             mirror,
    output logic [CHR_BANK_W+CHR_PAGE_W-1:0]    chr_addr,
    output logic                                nt_page
);

    logic [CHR_SEL_W-1:0] sel;

    always_comb begin
        sel      = vid_addr[CHR_PAGE_W+CHR_SEL_W-1:CHR_PAGE_W];
        chr_addr = {chr[sel], vid_addr[CHR_PAGE_W-1:0]};
        unique case (mirror)
            MIR_VERT:   nt_page = vid_addr[10];
            MIR_HORZ:   nt_page = vid_addr[11];
            MIR_ONE_LO: nt_page = 1'b0;
            default:    nt_page = 1'b1;
        endcase
    end

    always_comb begin
        if (mirror == MIR_ONE_LO) begin
            assert_single_lo_R5: assert (!nt_page);
        end
        if (mirror == MIR_ONE_HI) begin
            assert_single_hi_R5: assert (nt_page);
        end
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    localparam int PRG_BANK_W = $clog2(PRG_BANKS),
    localparam int PRG_ADDR_W = PRG_BANK_W + PRG_PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr_en,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic [PRG_ADDR_W-1:0] prg_addr,
    input  logic [13:0]           vid_addr,
    output logic [17:0]           chr_addr,
    output logic                  nt_page
);

    logic [PRG_BANK_W-1:0]               prg_a, prg_b;
    mirror_e                             mirror;
    logic [CHR_REGS-1:0][CHR_BANK_W-1:0] chr;

    cbc_regs #(.PRG_BANK_W(PRG_BANK_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr_en),
        .addr     (cpu_addr),
        .wdata    (cpu_wdata),
        .prg_a_q  (prg_a),
        .prg_b_q  (prg_b),
        .mirror_q (mirror),
        .chr_q    (chr)
    );

    cbc_prg_map #(.PRG_BANKS(PRG_BANKS), .PRG_BANK_W(PRG_BANK_W)) u_prg (
        .cpu_addr (cpu_addr),
        .prg_a    (prg_a),
        .prg_b    (prg_b),
        .prg_addr (prg_addr)
    );

    cbc_chr_map u_chr (
        .vid_addr (vid_addr),
        .chr      (chr),
        .mirror   (mirror),
        .chr_addr (chr_addr),
        .nt_page  (nt_page)
    );

endmodule

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;

    localparam int PRG_BANKS = 32;
    localparam int BW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic [17:0] prg_addr;
    logic [13:0] vid_addr = 14'h0;
    logic [17:0] chr_addr;
    logic        nt_page;

    int checks = 0;
    int errors = 0;

    logic [BW-1:0] m_prg [2];
    logic [1:0]    m_mir;
    logic [7:0]    m_chr [8];

    always #2 clk = ~clk;

    cart_bank_ctrl #(.PRG_BANKS(PRG_BANKS)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .prg_addr(prg_addr), .vid_addr(vid_addr),
        .chr_addr(chr_addr), .nt_page(nt_page)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prg[0] = 0; m_prg[1] = 1; m_mir = 0;
        for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a == 16'h8000) m_prg[0] = d[BW-1:0];
        else if (a == 16'hA000) m_prg[1] = d[BW-1:0];
        else if (a == 16'h9000) m_mir = d[1:0];
        else begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] base;
                base = 16'hB000 + 16'((i / 2) * 16'h1000) + 16'((i % 2) * 2);
                if (a == base) m_chr[i][3:0] = d[3:0];
                if (a == base + 16'd1) m_chr[i][7:4] = d[3:0];
            end
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_prg(input string req);
        for (int w = 0; w < 4; w++) begin
            logic [BW-1:0] b;
            cpu_addr = 16'h8000 | 16'(w << 13) | 16'h0123;
            #1;
            b = (w == 0) ? m_prg[0] : (w == 1) ? m_prg[1] :
                (w == 2) ? BW'(PRG_BANKS - 2) : BW'(PRG_BANKS - 1);
            chk(req, 32'(prg_addr), 32'({b, 13'h0123}));
        end
    endtask

    task automatic check_chr(input string req);
        for (int i = 0; i < 8; i++) begin
            vid_addr = {1'b0, 3'(i), 10'h2A5};
            #1;
            chk(req, 32'(chr_addr), 32'({m_chr[i], 10'h2A5}));
        end
    endtask

    task automatic check_nt(input string req);
        for (int b = 0; b < 4; b++) begin
            logic e;
            vid_addr = 14'h2000 | 14'(b << 10);
            #1;
            case (m_mir)
                2'd0: e = b[0];
                2'd1: e = b[1];
                2'd2: e = 1'b0;
                default: e = 1'b1;
            endcase
            chk(req, 32'(nt_page), 32'(e));
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        check_prg(req); check_chr(req); check_nt(req);
    endtask

    task automatic t_reset();
        model_reset();
        check_all("R1 reset state");
    endtask

    task automatic t_prg();
        wr(16'h8000, 8'h07); wr(16'hA000, 8'h1C);
        check_prg("R2 prg switch");
        wr(16'h8000, 8'hE3);
        check_prg("R2 prg truncate");
    endtask

    task automatic t_fixed();
        wr(16'hC000, 8'h3F); wr(16'hE000, 8'h01);
        check_prg("R3 fixed windows");
    endtask

    task automatic t_mirror();
        logic [7:0] vals [4] = '{8'hFC, 8'h01, 8'hA6, 8'h53};
        foreach (vals[k]) begin
            wr(16'h9000, vals[k]);
            check_nt(k[0] ? "R5 nametable page" : "R4 mirror mode");
        end
    endtask

    task automatic t_chr();
        for (int i = 0; i < 8; i++) begin
            logic [15:0] base;
            base = 16'hB000 + 16'((i / 2) * 16'h1000) + 16'((i % 2) * 2);
            wr(base, 8'hF0 | 8'(i + 8));
            check_chr("R6 pair order low");
            wr(base + 16'd1, 8'hA0 | 8'(15 - i));
            check_chr("R7 high nibble");
        end
        wr(16'hC002, 8'h55);
        check_chr("R7 low nibble keeps high");
        check_chr("R8 chr translate");
    endtask

    task automatic t_ignored();
        logic [15:0] bad [8] = '{16'h8001, 16'h9001, 16'hA001, 16'hB004,
                                 16'hF00C, 16'hF000, 16'h1000, 16'hE103};
        foreach (bad[k]) wr(bad[k], 8'h9E);
        check_all("R9 unlisted address");
        @(negedge clk);
        cpu_wr_en = 1'b0; cpu_addr = 16'h8000; cpu_wdata = 8'h11;
        @(negedge clk);
        check_all("R9 no strobe");
    endtask

    task automatic t_timing();
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = 16'hA000; cpu_wdata = 8'h09;
        #1;
        chk("R10 before edge", 32'(prg_addr), 32'({m_prg[1], 13'h0000}));
        @(posedge clk); #1;
        chk("R10 after edge", 32'(prg_addr), 32'({5'h09, 13'h0000}));
        @(negedge clk);
        cpu_wr_en = 1'b0;
        model_write(16'hA000, 8'h09);
        check_prg("R10 settled");
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prg();
        t_fixed();
        t_mirror();
        t_chr();
        t_ignored();
        t_timing();
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule